// File: doc/BRIEF.md
# Serial memory page write engine

This block sits between the serial command decoder of a non-volatile memory and its storage array. When the decoder has recognised a write command and the target address, it pulses `start_i` with that address. Each data byte then arrives as a one-cycle strobe and lands in a page-sized staging buffer. The address moves forward only inside the page: after the last byte of the page it returns to the first, and a later byte replaces one already staged.

The decoder raises `commit_i` when chip select goes high. If at least one byte was staged, the engine then becomes busy. It walks every position of the page in ascending order and strobes the array only for positions that were filled during this sequence, so all other bytes keep their old contents. It then counts a set number of slow timebase ticks to model the self-timed programming period. When that period ends, busy drops and the engine sends one pulse to clear the write-enable latch.

An abort before the commit throws away the staged bytes. While busy, every request from the decoder is ignored and programming runs to the end.

Top module: `pgwr_engine`

## Requirements
- R1: After reset `busy_o`, `arr_we_o` and `wel_clr_o` are all 0.
- R2: A sequence started at address A puts its first byte at in-page offset A mod PAGE_BYTES. Each later byte goes to the next offset. Every array write of that sequence carries the page bits of A (address bits above the low log2(PAGE_BYTES) bits).
- R3: After the byte at offset PAGE_BYTES-1, the next byte goes to offset 0 of the same page. When one offset receives several bytes, the last byte received is the one written to the array.
- R4: Only offsets that received a byte in the sequence are strobed to the array. Each such offset is strobed exactly once, with `arr_addr_o` = page bits of A followed by the offset and `arr_data_o` = its byte.
- R5: No array write happens before `commit_i`. A commit with no staged byte starts nothing: `busy_o` stays 0 and no `wel_clr_o` pulse follows.
- R6: `busy_o` rises in the cycle after a commit that has staged bytes. It stays high through PAGE_BYTES programming cycles and then until CYCLE_TICKS `tick_i` pulses have been counted. It falls in the cycle after the last counted tick.
- R7: While `busy_o` is 1, `start_i`, `byte_vld_i`, `commit_i` and `abort_i` have no effect. No extra writes occur, the busy period is not shortened, and no sequence is open when busy ends.
- R8: `wel_clr_o` is high for exactly one cycle, in the first cycle after `busy_o` falls at the end of a committed cycle.
- R9: `abort_i` during a sequence discards the staged bytes. No write follows, `busy_o` stays 0, and no `wel_clr_o` pulse is issued. A later sequence to the same page commits only its own bytes.
- R10: Within one commit, array write addresses strictly increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a write sequence (ignored unless idle) |
| start_addr_i | input | ADDR_W | Target byte address of the sequence |
| byte_vld_i | input | 1 | One data byte is present |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Chip-select rising edge after the sequence |
| abort_i | input | 1 | Discard the open sequence |
| tick_i | input | 1 | Slow timebase pulse, one system clock wide |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The assertions assume that `commit_i` is the only event that can raise busy. They also assume that `tick_i` is counted only once programming has finished, so a busy period is never shorter than the programming walk. The stimulus follows the decoder contract: it opens a sequence with `start_i` before sending bytes and gives at most one control strobe per cycle. Ticks are held back until the programming walk is over, so the count of ticks seen by the bench matches the count seen by the timer. The stimulus that must be ignored is applied only inside busy windows, and its lack of effect is confirmed at the array and status ports.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_WAIT    = 2'd3
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFF_W-1:0] load_off_i,
    input  logic             wr_i,
    input  logic [7:0]       data_i,
    input  logic             clr_i,
    input  logic [OFF_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_vld_o,
    output logic             any_o
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    typedef struct packed {
        logic [OFF_W-1:0]                 offs;
        logic [PAGE_BYTES-1:0]            mask;
        logic [PAGE_BYTES-1:0][7:0]       bytes;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load_i) begin
            buf_d.offs = load_off_i;
            buf_d.mask = '0;
        end else if (clr_i) begin
            buf_d.mask = '0;
        end else if (wr_i) begin
            buf_d.bytes[buf_q.offs] = data_i;
            buf_d.mask[buf_q.offs]  = 1'b1;
            buf_d.offs = (buf_q.offs == LAST_OFF) ? '0 : buf_q.offs + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_data_o = buf_q.bytes[rd_idx_i];
    assign rd_vld_o  = buf_q.mask[rd_idx_i];
    assign any_o     = |buf_q.mask;

    // R3: the in-page offset wraps from the last position to the first
    assert_offset_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !load_i && !clr_i && buf_q.offs == LAST_OFF) |=> (buf_q.offs == '0));

    // R2: a written position is marked valid on the following cycle
    assert_mark_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !load_i && !clr_i) |=> buf_q.mask[$past(buf_q.offs)]);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int CYCLE_TICKS = 5,
    localparam int TCNT_W = $clog2(CYCLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic done_o
);
    localparam logic [TCNT_W-1:0] LAST_CNT = TCNT_W'(CYCLE_TICKS - 1);

    typedef struct packed {
        logic              run;
        logic [TCNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = 1'b0;
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run && tick_i) begin
            if (tmr_q.cnt == LAST_CNT) begin
                tmr_d.run = 1'b0;
                done_o    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R6: the timer stops only when a tick arrives
    assert_stop_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.run) |-> $past(tick_i));
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int ADDR_W      = 11,
    parameter int CYCLE_TICKS = 5,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              commit_i,
    input  logic              abort_i,
    input  logic              tick_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o,
    output logic              busy_o,
    output logic              wel_clr_o
);
    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(PAGE_BYTES - 1);

    typedef struct packed {
        pgwr_state_e      st;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] idx;
        logic             wclr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic       buf_load, buf_wr, buf_clr, buf_vld, buf_any;
    logic [7:0] buf_data;
    logic       tmr_start, tmr_done;

    always_comb begin
        eng_d      = eng_q;
        eng_d.wclr = 1'b0;
        buf_load   = 1'b0;
        buf_wr     = 1'b0;
        buf_clr    = 1'b0;
        tmr_start  = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    buf_load   = 1'b1;
                    eng_d.page = start_addr_i[ADDR_W-1:OFF_W];
                    eng_d.st   = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (abort_i) begin
                    buf_clr  = 1'b1;
                    eng_d.st = ST_IDLE;
                end else if (commit_i) begin
                    eng_d.idx = '0;
                    eng_d.st  = buf_any ? ST_PROGRAM : ST_IDLE;
                end else if (byte_vld_i) begin
                    buf_wr = 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (eng_q.idx == LAST_IDX) begin
                    tmr_start = 1'b1;
                    buf_clr   = 1'b1;
                    eng_d.st  = ST_WAIT;
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    eng_d.wclr = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, page: '0, idx: '0, wclr: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    pgwr_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (buf_load),
        .load_off_i (start_addr_i[OFF_W-1:0]),
        .wr_i       (buf_wr),
        .data_i     (byte_i),
        .clr_i      (buf_clr),
        .rd_idx_i   (eng_q.idx),
        .rd_data_o  (buf_data),
        .rd_vld_o   (buf_vld),
        .any_o      (buf_any)
    );

    pgwr_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .tick_i  (tick_i),
        .done_o  (tmr_done)
    );

    assign arr_we_o   = (eng_q.st == ST_PROGRAM) && buf_vld;
    assign arr_addr_o = {eng_q.page, eng_q.idx};
    assign arr_data_o = buf_data;
    assign busy_o     = (eng_q.st == ST_PROGRAM) || (eng_q.st == ST_WAIT);
    assign wel_clr_o  = eng_q.wclr;

    // R5: the array is only written inside a busy cycle
    assert_we_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    // R6: busy starts only as a result of a commit
    assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_i));

    // R8: write-enable clear is a single pulse right after busy ends
    assert_welclr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |=> !wel_clr_o);
    assert_welclr_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> (!busy_o && $past(busy_o)));

    // R2: consecutive writes stay in one page
    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && $past(arr_we_o)) |->
        (arr_addr_o[ADDR_W-1:OFF_W] == $past(arr_addr_o[ADDR_W-1:OFF_W])));

    // R10: addresses of back-to-back writes increase
    assert_addr_rising_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o > $past(arr_addr_o)));
endmodule

// File: tb/tb_pgwr_engine.sv
module tb_pgwr_engine;
    localparam int PAGE_BYTES  = 16;
    localparam int ADDR_W      = 11;
    localparam int CYCLE_TICKS = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              byte_vld_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic              commit_i = 1'b0;
    logic              abort_i = 1'b0;
    logic              tick_i = 1'b0;
    logic              arr_we_o;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [7:0]        arr_data_o;
    logic              busy_o;
    logic              wel_clr_o;

    int errors = 0;
    int checks = 0;
    int wn = 0;
    int wclr_n = 0;
    logic [ADDR_W-1:0] la [0:63];
    logic [7:0]        ld [0:63];

    always #4 clk = ~clk;

    pgwr_engine #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .CYCLE_TICKS(CYCLE_TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i), .abort_i(abort_i),
        .tick_i(tick_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_data_o(arr_data_o), .busy_o(busy_o), .wel_clr_o(wel_clr_o)
    );

    always @(negedge clk) begin
        if (rst_n && arr_we_o && wn < 64) begin
            la[wn] = arr_addr_o;
            ld[wn] = arr_data_o;
            wn++;
        end
        if (rst_n && wel_clr_o) wclr_n++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic open_seq(input logic [ADDR_W-1:0] a);
        start_i = 1'b1; start_addr_i = a; cyc(); start_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_vld_i = 1'b1; byte_i = b; cyc(); byte_vld_i = 1'b0;
    endtask

    task automatic do_commit();
        commit_i = 1'b1; cyc(); commit_i = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_i = 1'b1; cyc(); tick_i = 1'b0; cyc();
    endtask

    task automatic drain(input string tag);
        repeat (PAGE_BYTES + 2) cyc();
        chk(busy_o == 1'b1, "R6 busy through programming", busy_o, 1);
        for (int i = 0; i < CYCLE_TICKS - 1; i++) pulse_tick();
        chk(busy_o == 1'b1, "R6 busy until last tick", busy_o, 1);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R6 busy falls after last tick", busy_o, 0);
        chk(wel_clr_o == 1'b1, "R8 wel clear pulse", wel_clr_o, 1);
        @(negedge clk);
        chk(wel_clr_o == 1'b0, "R8 wel clear one cycle", wel_clr_o, 0);
        cyc();
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(arr_we_o == 1'b0, "R1 we", arr_we_o, 0);
        chk(wel_clr_o == 1'b0, "R1 wel", wel_clr_o, 0);
    endtask

    task automatic t_basic();
        wn = 0;
        open_seq(11'h123);
        for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i));
        repeat (3) cyc();
        chk(wn == 0, "R5 no write before commit", wn, 0);
        do_commit();
        @(negedge clk);
        chk(busy_o == 1'b1, "R6 busy rises after commit", busy_o, 1);
        drain("basic");
        chk(wn == 4, "R4 write count basic", wn, 4);
        for (int i = 0; i < 4; i++) begin
            chk(la[i] == 11'h123 + 11'(i), "R2 address basic", la[i], 11'h123 + i);
            chk(ld[i] == 8'hA0 + 8'(i), "R2 data basic", ld[i], 8'hA0 + i);
        end
    endtask

    task automatic t_wrap();
        logic [7:0] expv [0:15];
        wn = 0;
        open_seq(11'h25E);
        for (int i = 0; i < 20; i++) begin
            expv[(14 + i) % 16] = 8'h10 + 8'(i);
            send(8'h10 + 8'(i));
        end
        do_commit();
        drain("wrap");
        chk(wn == 16, "R3 wrap write count", wn, 16);
        for (int k = 0; k < 16; k++) begin
            chk(la[k] == 11'h250 + 11'(k), "R10 wrap ascending address", la[k], 11'h250 + k);
            chk(ld[k] == expv[k], "R3 last byte wins", ld[k], expv[k]);
        end
    endtask

    task automatic t_sparse();
        wn = 0;
        open_seq(11'h305);
        send(8'h5A); send(8'hC3);
        do_commit();
        drain("sparse");
        chk(wn == 2, "R4 only written offsets", wn, 2);
        chk(la[0] == 11'h305 && ld[0] == 8'h5A, "R4 first sparse", la[0], 11'h305);
        chk(la[1] == 11'h306 && ld[1] == 8'hC3, "R4 second sparse", la[1], 11'h306);
    endtask

    task automatic t_empty();
        int w0;
        wn = 0; w0 = wclr_n;
        open_seq(11'h040);
        do_commit();
        repeat (PAGE_BYTES + 4) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R5 empty commit not busy", busy_o, 0);
        end
        cyc();
        chk(wn == 0, "R5 empty commit no write", wn, 0);
        chk(wclr_n == w0, "R5 empty commit no wel clear", wclr_n - w0, 0);
    endtask

    task automatic t_abort();
        int w0;
        wn = 0; w0 = wclr_n;
        open_seq(11'h400);
        send(8'h11); send(8'h22); send(8'h33);
        abort_i = 1'b1; cyc(); abort_i = 1'b0;
        do_commit();
        repeat (PAGE_BYTES + 4) cyc();
        chk(busy_o == 1'b0, "R9 abort no busy", busy_o, 0);
        chk(wn == 0, "R9 abort no write", wn, 0);
        chk(wclr_n == w0, "R9 abort no wel clear", wclr_n - w0, 0);
        open_seq(11'h402);
        send(8'h77);
        do_commit();
        drain("abort2");
        chk(wn == 1, "R9 old bytes discarded", wn, 1);
        chk(la[0] == 11'h402 && ld[0] == 8'h77, "R9 new byte only", la[0], 11'h402);
    endtask

    task automatic t_busy_ignore();
        wn = 0;
        open_seq(11'h510);
        send(8'h99);
        do_commit();
        repeat (PAGE_BYTES + 2) cyc();
        open_seq(11'h600);
        send(8'hEE);
        abort_i = 1'b1; cyc(); abort_i = 1'b0;
        do_commit();
        chk(busy_o == 1'b1, "R7 busy kept through ignored inputs", busy_o, 1);
        for (int i = 0; i < CYCLE_TICKS - 1; i++) pulse_tick();
        chk(busy_o == 1'b1, "R7 busy not shortened", busy_o, 1);
        pulse_tick();
        chk(busy_o == 1'b0, "R7 busy ends on tick count", busy_o, 0);
        send(8'h44);
        do_commit();
        repeat (PAGE_BYTES + 4) cyc();
        chk(busy_o == 1'b0, "R7 no sequence open after busy", busy_o, 0);
        chk(wn == 1, "R7 no extra writes", wn, 1);
        chk(la[0] == 11'h510 && ld[0] == 8'h99, "R7 only real write", la[0], 11'h510);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) cyc();
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_basic();
        t_wrap();
        t_sparse();
        t_empty();
        t_abort();
        t_busy_ignore();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule